// File: doc/BRIEF.md
# Label-Switching Processor Host Command Port

This block is the host-facing slave of a label-switching control processor. It sits on a memory-mapped bus with a 4-bit address, 32-bit read and write data, and a wait-request stall. Writes and reads decode the same address field differently. Writes fill staging registers: six path words, three link words, a port-assignment word, a flags/TTL word, an initial-label word and a packet word. Reads return an outgoing packet word, a status word and the two labels of the currently referenced path.

Address 13 is the control register. Bits [3:0] hold a command code and bits [8:4] hold a zero-based path index. A valid command produces a one-cycle strobe toward the internal engines and raises waitrequest. Waitrequest stays high until the engines report completion, and every bus transfer stalls during that time. The core engines behind the strobes are outside this block.

Top module: `lsp_host_port`

## Requirements
- R1: After the asynchronous reset (rst_n low), all staged words, pkt_wdata, path_ref and cmd_strobe are zero, and waitrequest and pkt_wstrobe are low.
- R2: An accepted write to address 0..5 stores writedata in path slot N = address, visible on path_stage[N*32 +: 32] in the next cycle. The other slots are unchanged.
- R3: An accepted write to address 6, 7 or 8 stores into link slot address-6 (link_stage[(address-6)*32 +: 32]). Address 9 stores into port_map, 10 into cfg_flags and 11 into init_label.
- R4: An accepted write to address 12 loads pkt_wdata and pulses pkt_wstrobe high for exactly the next cycle.
- R5: An accepted write to address 13 whose bits [3:0] hold code C in 0..11 sets cmd_strobe bit C, and only that bit, for exactly the next cycle. The same write loads path_ref from bits [8:4]. Bits [31:9] have no effect. Codes are 0 reset, 1 clear input stack, 2 clear output stack, 3 clear path data, 4 clear link data, 5 path teardown, 6 reservation teardown, 7 process packet, 8 establish paths, 9 save path, 10 save link, 11 save packet.
- R6: waitrequest rises together with the strobe of a valid command. It stays high until the clock edge at which cmd_done is sampled high, and it is low in the following cycle.
- R7: Codes 12..15 written to address 13 produce no strobe, do not raise waitrequest and leave path_ref unchanged.
- R8: While waitrequest is high no write or read is accepted: staging, strobes and pops are unaffected. A write held on the bus is accepted at the first edge after waitrequest falls.
- R9: readdata returns pkt_rdata at address 0, status_word at 1, in_label at 2, out_label at 3, and zero at 4..15.
- R10: pkt_rd_pop is high in a cycle exactly when read is high, address is 0 and waitrequest is low.
- R11: An accepted code 0 command also clears all path, link, port, flags, initial-label and packet staging words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| address | input | 4 | Bus word address |
| write | input | 1 | Write request |
| writedata | input | 32 | Write data |
| read | input | 1 | Read request |
| readdata | output | 32 | Read data, valid in the cycle the read is accepted |
| waitrequest | output | 1 | Stall: a command is executing |
| path_stage | output | 192 | Six staged path words, slot N at bits N*32 +: 32 |
| link_stage | output | 96 | Three staged link words |
| port_map | output | 32 | Staged port assignments |
| cfg_flags | output | 32 | Staged packet flags and initial TTL |
| init_label | output | 32 | Staged first assignable label |
| pkt_wdata | output | 32 | Last packet word written |
| pkt_wstrobe | output | 1 | One-cycle pulse per packet word written |
| cmd_strobe | output | 12 | One-hot command pulse, bit = command code |
| path_ref | output | 5 | Path index of the last valid command |
| cmd_done | input | 1 | Core reports that the current command has finished |
| pkt_rdata | input | 32 | Head of the outgoing packet queue |
| pkt_rd_pop | output | 1 | Consume the outgoing packet word |
| status_word | input | 32 | Core status |
| in_label | input | 32 | Incoming label of the referenced path |
| out_label | input | 32 | Outgoing label of the referenced path |

## Verification
The assertions check properties that hold on every cycle. The command strobe is one-hot and lasts a single cycle. Waitrequest accompanies every strobe, holds until completion and drops right after it. No staging word changes and no strobe or pop occurs while stalled. Undefined read addresses return zero, and a packet pop is tied to an accepted read. Only the directed scenarios can show the data side: each address reaching the right slot, the command code and path index selected from a word with noisy upper bits, a stalled write landing after release, and the reset command wiping the staging.

// File: rtl/lsp_host_port.sv
module lsp_host_port #(
  parameter int DW    = 32,
  parameter int REFW  = 5,
  parameter int NPATH = 6,
  parameter int NLINK = 3,
  parameter int NCMD  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          address,
  input  logic                write,
  input  logic [DW-1:0]       writedata,
  input  logic                read,
  output logic [DW-1:0]       readdata,
  output logic                waitrequest,
  output logic [NPATH*DW-1:0] path_stage,
  output logic [NLINK*DW-1:0] link_stage,
  output logic [DW-1:0]       port_map,
  output logic [DW-1:0]       cfg_flags,
  output logic [DW-1:0]       init_label,
  output logic [DW-1:0]       pkt_wdata,
  output logic                pkt_wstrobe,
  output logic [NCMD-1:0]     cmd_strobe,
  output logic [REFW-1:0]     path_ref,
  input  logic                cmd_done,
  input  logic [DW-1:0]       pkt_rdata,
  output logic                pkt_rd_pop,
  input  logic [DW-1:0]       status_word,
  input  logic [DW-1:0]       in_label,
  input  logic [DW-1:0]       out_label
);
  localparam logic [3:0] A_LINK0 = 4'(NPATH);
  localparam logic [3:0] A_PORT  = 4'(NPATH + NLINK);
  localparam logic [3:0] A_FLAGS = A_PORT + 4'd1;
  localparam logic [3:0] A_LABEL = A_PORT + 4'd2;
  localparam logic [3:0] A_PKT   = A_PORT + 4'd3;
  localparam logic [3:0] A_CTRL  = A_PORT + 4'd4;

  logic          busy;
  logic [DW-1:0] path_q [NPATH];
  logic [DW-1:0] link_q [NLINK];
  logic          wr_ok, ctl_wr, cmd_ok;
  logic [3:0]    code;

  assign waitrequest = busy;
  assign wr_ok       = write && !busy;
  assign ctl_wr      = wr_ok && (address == A_CTRL);
  assign code        = writedata[3:0];
  assign cmd_ok      = ctl_wr && (code < 4'(NCMD));
  assign pkt_rd_pop  = read && !busy && (address == 4'd0);

  for (genvar i = 0; i < NPATH; i++) begin : g_path
    assign path_stage[i*DW +: DW] = path_q[i];
  end
  for (genvar i = 0; i < NLINK; i++) begin : g_link
    assign link_stage[i*DW +: DW] = link_q[i];
  end

  always_comb begin
    case (address)
      4'd0:    readdata = pkt_rdata;
      4'd1:    readdata = status_word;
      4'd2:    readdata = in_label;
      4'd3:    readdata = out_label;
      default: readdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      pkt_wstrobe <= 1'b0;
      pkt_wdata   <= '0;
      cmd_strobe  <= '0;
      path_ref    <= '0;
      port_map    <= '0;
      cfg_flags   <= '0;
      init_label  <= '0;
      for (int i = 0; i < NPATH; i++) path_q[i] <= '0;
      for (int i = 0; i < NLINK; i++) link_q[i] <= '0;
    end else begin
      pkt_wstrobe <= wr_ok && (address == A_PKT);
      cmd_strobe  <= '0;
      if (busy && cmd_done) busy <= 1'b0;
      if (wr_ok) begin
        for (int i = 0; i < NPATH; i++)
          if (address == 4'(i)) path_q[i] <= writedata;
        for (int i = 0; i < NLINK; i++)
          if (address == A_LINK0 + 4'(i)) link_q[i] <= writedata;
        if (address == A_PORT)  port_map   <= writedata;
        if (address == A_FLAGS) cfg_flags  <= writedata;
        if (address == A_LABEL) init_label <= writedata;
        if (address == A_PKT)   pkt_wdata  <= writedata;
      end
      if (cmd_ok) begin
        busy     <= 1'b1;
        path_ref <= writedata[4 +: REFW];
        for (int i = 0; i < NCMD; i++)
          if (code == 4'(i)) cmd_strobe[i] <= 1'b1;
        if (code == 4'd0) begin
          port_map   <= '0;
          cfg_flags  <= '0;
          init_label <= '0;
          pkt_wdata  <= '0;
          for (int i = 0; i < NPATH; i++) path_q[i] <= '0;
          for (int i = 0; i < NLINK; i++) link_q[i] <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/lsp_host_port_chk.sv
module lsp_host_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  address,
  input logic        write,
  input logic        read,
  input logic [31:0] readdata,
  input logic        waitrequest,
  input logic [191:0] path_stage,
  input logic [95:0] link_stage,
  input logic        pkt_wstrobe,
  input logic [11:0] cmd_strobe,
  input logic        cmd_done,
  input logic        pkt_rd_pop
);
  p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_strobe));
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_strobe) |=> !(|cmd_strobe));
  p_busy_with_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_strobe) |-> waitrequest);
  p_busy_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (waitrequest && cmd_done) |=> !waitrequest);
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (waitrequest && !cmd_done) |=> waitrequest);
  p_no_strobe_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    waitrequest |=> !(|cmd_strobe) && !pkt_wstrobe);
  p_stage_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    waitrequest |=> $stable(path_stage) && $stable(link_stage));
  p_undef_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (address > 4'd3) |-> (readdata == 32'd0));
  p_pop_accepted_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rd_pop |-> (read && !waitrequest && address == 4'd0));
  p_pkt_strobe_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_wstrobe |-> $past(write && !waitrequest && address == 4'd12));
endmodule

bind lsp_host_port lsp_host_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .address(address), .write(write), .read(read),
  .readdata(readdata), .waitrequest(waitrequest), .path_stage(path_stage),
  .link_stage(link_stage), .pkt_wstrobe(pkt_wstrobe), .cmd_strobe(cmd_strobe),
  .cmd_done(cmd_done), .pkt_rd_pop(pkt_rd_pop)
);

// File: tb/lsp_host_port_test.sv
`timescale 1ns/1ps
module lsp_host_port_test;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  address = 0;
  logic        write = 0, read = 0, cmd_done = 0;
  logic [31:0] writedata = 0, readdata;
  logic        waitrequest, pkt_wstrobe, pkt_rd_pop;
  logic [191:0] path_stage;
  logic [95:0] link_stage;
  logic [31:0] port_map, cfg_flags, init_label, pkt_wdata;
  logic [11:0] cmd_strobe;
  logic [4:0]  path_ref;
  logic [31:0] pkt_rdata = 32'hA1A1_0001, status_word = 32'h5757_0002;
  logic [31:0] in_label = 32'h0001_0010, out_label = 32'h0002_0020;
  int checks = 0, errors = 0, done_lat = 3, cnt = 0;

  always #5 clk = ~clk;

  lsp_host_port uut (.*);

  always @(negedge clk) begin
    cmd_done = 0;
    if (|cmd_strobe) cnt = done_lat;
    else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) cmd_done = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); address = a; writedata = d; write = 1;
    while (waitrequest) @(negedge clk);
    @(negedge clk); write = 0;
  endtask

  task automatic wait_idle();
    while (waitrequest) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(path_stage == 0 && link_stage == 0, "R1 stage", {path_stage}, 0);
    chk(port_map == 0 && cfg_flags == 0 && init_label == 0 && pkt_wdata == 0, "R1 cfg", port_map, 0);
    chk(!waitrequest && !pkt_wstrobe && cmd_strobe == 0 && path_ref == 0, "R1 ctl", cmd_strobe, 0);
  endtask

  task automatic t_path();
    for (int i = 0; i < 6; i++) bus_write(4'(i), 32'h1000_0000 + i);
    for (int i = 0; i < 6; i++)
      chk(path_stage[i*32 +: 32] == 32'h1000_0000 + i, "R2 slot", path_stage[i*32 +: 32], 32'h1000_0000 + i);
    bus_write(4'd2, 32'hDEAD_0002);
    chk(path_stage[2*32 +: 32] == 32'hDEAD_0002 && path_stage[3*32 +: 32] == 32'h1000_0003,
        "R2 single", path_stage[2*32 +: 64], {32'h1000_0003, 32'hDEAD_0002});
  endtask

  task automatic t_link_cfg();
    for (int i = 0; i < 3; i++) bus_write(4'(6 + i), 32'h2000_0000 + i);
    bus_write(4'd9, 32'h3333_0009);
    bus_write(4'd10, 32'h4444_000A);
    bus_write(4'd11, 32'h5555_000B);
    chk(link_stage == {32'h2000_0002, 32'h2000_0001, 32'h2000_0000}, "R3 link", link_stage, 0);
    chk(port_map == 32'h3333_0009 && cfg_flags == 32'h4444_000A && init_label == 32'h5555_000B,
        "R3 cfg", {port_map, cfg_flags, init_label}, {32'h3333_0009, 32'h4444_000A, 32'h5555_000B});
  endtask

  task automatic t_pkt();
    bus_write(4'd12, 32'hCAFE_F00D);
    chk(pkt_wstrobe && pkt_wdata == 32'hCAFE_F00D, "R4 pulse", {pkt_wstrobe, pkt_wdata}, {1'b1, 32'hCAFE_F00D});
    @(negedge clk);
    chk(!pkt_wstrobe, "R4 single", pkt_wstrobe, 0);
  endtask

  task automatic t_commands();
    for (int c = 1; c < 12; c++) begin
      int n = 0;
      logic [4:0] r = 5'(c * 3 + 1);
      bus_write(4'd13, 32'hABCD_EE00 | (32'(r) << 4) | 32'(c));
      chk(cmd_strobe == 12'(1 << c) && path_ref == r, "R5 strobe", {cmd_strobe, path_ref}, {12'(1 << c), r});
      chk(waitrequest, "R6 rise", waitrequest, 1);
      @(negedge clk);
      chk(cmd_strobe == 0, "R5 single", cmd_strobe, 0);
      n = 1;
      while (waitrequest) begin @(negedge clk); n++; end
      chk(n == done_lat + 1, "R6 length", n, done_lat + 1);
    end
  endtask

  task automatic t_nop();
    logic [4:0] keep = path_ref;
    for (int c = 12; c < 16; c++) begin
      bus_write(4'd13, 32'h0000_01F0 | 32'(c));
      chk(cmd_strobe == 0 && !waitrequest && path_ref == keep, "R7 nop", {cmd_strobe, waitrequest, path_ref}, {12'd0, 1'b0, keep});
    end
  endtask

  task automatic t_stall();
    int early = 0;
    done_lat = 5;
    bus_write(4'd13, 32'h0000_0039);
    address = 4'd4; writedata = 32'h7777_7777; write = 1;
    @(negedge clk);
    chk(path_stage[4*32 +: 32] == 32'h1000_0004, "R8 data stalled", path_stage[4*32 +: 32], 32'h1000_0004);
    address = 4'd13; writedata = 32'h0000_005A;
    while (waitrequest) begin @(negedge clk); if (|cmd_strobe) early++; end
    chk(early == 0, "R8 ctl stalled", early, 0);
    @(negedge clk); write = 0;
    chk(cmd_strobe == 12'h400 && path_ref == 5, "R8 released", {cmd_strobe, path_ref}, {12'h400, 5'd5});
    wait_idle();
    bus_write(4'd4, 32'h7777_7777);
    chk(path_stage[4*32 +: 32] == 32'h7777_7777, "R8 later write", path_stage[4*32 +: 32], 32'h7777_7777);
    done_lat = 3;
  endtask

  task automatic t_reads();
    logic [31:0] e;
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); address = 4'(a); read = 1; #1;
      e = a == 0 ? pkt_rdata : a == 1 ? status_word : a == 2 ? in_label : a == 3 ? out_label : 32'd0;
      chk(readdata == e, "R9 readdata", readdata, e);
      chk(pkt_rd_pop == (a == 0), "R10 pop", pkt_rd_pop, a == 0);
    end
    @(negedge clk); read = 0; #1;
    chk(!pkt_rd_pop, "R10 no read", pkt_rd_pop, 0);
    bus_write(4'd13, 32'h7);
    address = 4'd0; read = 1; #1;
    chk(!pkt_rd_pop, "R10 stalled", pkt_rd_pop, 0);
    read = 0;
    wait_idle();
  endtask

  task automatic t_reset_cmd();
    bus_write(4'd13, 32'h0000_0020);
    chk(cmd_strobe == 12'h001 && path_ref == 2, "R5 code0", {cmd_strobe, path_ref}, {12'h001, 5'd2});
    chk(path_stage == 0 && link_stage == 0 && port_map == 0 && cfg_flags == 0 && init_label == 0 && pkt_wdata == 0,
        "R11 cleared", path_stage, 0);
    wait_idle();
  endtask

  initial begin
    #200_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #23 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_path();
    t_link_cfg();
    t_pkt();
    t_commands();
    t_nop();
    t_stall();
    t_reads();
    t_reset_cmd();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule